// File: doc/BRIEF.md
# Delayed Read Request Tracker

This block keeps the accounting for up to four delayed-read buffers inside a bus bridge. When the downstream bus side opens a read into a free buffer, the tracker starts issuing upstream read subrequests for it. Each subrequest covers one 64-byte line (16 DW) and carries a tag that names the buffer and a running subrequest number. The tracker counts the subrequests that are still in flight and the lines held for each buffer. It also keeps the total held across all buffers within a shared 256 DW store (16 lines).

Software picks how many buffers are active, how many lines one read may prefetch (1 to 8, which is 16 to 128 DW), and one of two prefetch modes. In single mode a read fetches its programmed line count once and then stops. In continuous mode the line count is a moving window, and each line drained to the requester lets one more subrequest go out. A disconnect discards the read's data. Any subrequests still in flight become stale: their completions are swallowed, and the buffer only returns to the free pool once the last of them has come back.

Top module: `delayed_read_tracker`

## Requirements
- R1: The number of active buffers is `cfg_nbuf`+1. A read request that names a buffer index at or above that count, or a buffer that is still busy (active or stale), is ignored.
- R2: With three or four active buffers, an issued tag is 5 bits: bit 4 is 0, bits 3:2 are the buffer index and bits 1:0 the subrequest number.
- R3: With one or two active buffers, an issued tag is 5 bits: bit 4 is 0, bit 3 is the buffer index and bits 2:0 the subrequest number.
- R4: Subrequest numbers for a buffer start at 0 on each new read, rise by one per issue, and wrap modulo 4 (three or four buffers) or modulo 8 (one or two buffers).
- R5: A buffer never has more than 4 (three or four buffers) or 8 (one or two buffers) subrequests in flight. Its `buf_full` bit is high exactly while that cap is reached.
- R6: In single mode (`cfg_cont`=0) a read issues exactly `cfg_lines_m1`+1 subrequests over its life and then stops.
- R7: In continuous mode a buffer's held lines (issued and not yet drained) never exceed `cfg_lines_m1`+1. A drain of a completed line frees one slot. A drain when the buffer holds no completed, undrained line is ignored.
- R8: The held lines summed over all buffers never exceed 16. A buffer that is otherwise ready waits until a drain or free makes room.
- R9: At most one subrequest issues per cycle, and the lowest-numbered eligible buffer wins. `iss_valid`/`iss_tag` are registered and appear the cycle after the decision.
- R10: A disconnect discards a buffer's drained-side data. With nothing in flight the buffer is free on the next cycle. Otherwise it turns stale: it issues nothing, each returning completion pulses `cpl_drop`, and it is freed when the last one returns.
- R11: A completion whose tag has bit 4 = 0 and names a live buffer with subrequests in flight pulses `cpl_accept` one cycle later. A completion with bit 4 = 1, or one for an idle buffer, produces neither pulse.
- R12: After reset no buffer is busy or full and nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nbuf | input | 2 | Active buffers minus one |
| cfg_lines_m1 | input | 3 | Lines per read (window size in continuous mode) minus one |
| cfg_cont | input | 1 | 1 = continuous moving-window prefetch |
| req_valid | input | 1 | New read opened |
| req_buf | input | 2 | Buffer for the new read |
| drain_valid | input | 1 | One line handed to the requester |
| drain_buf | input | 2 | Buffer that drained |
| disc_valid | input | 1 | Read disconnected |
| disc_buf | input | 2 | Buffer that disconnected |
| cpl_valid | input | 1 | Subrequest completion |
| cpl_tag | input | 5 | Tag of the completed subrequest |
| iss_valid | output | 1 | Subrequest issue strobe |
| iss_tag | output | 5 | Tag of the issued subrequest |
| cpl_accept | output | 1 | Completion counted for a live read |
| cpl_drop | output | 1 | Completion discarded for a stale read |
| buf_busy | output | 4 | Buffer live or stale, per buffer |
| buf_full | output | 4 | In-flight cap reached, per buffer |

## Verification
The bench sweeps every buffer count against every usable buffer and checks the exact tag sequence, so a field taken from the wrong bits, or a wrap at the wrong width, shows up as a mismatched tag. It drives a buffer to its in-flight cap in both tag layouts, then past a wrap, to catch a cap of the wrong size or numbering that fails to restart at zero. It disconnects with completions pending, which catches a buffer that reopens early or counts stale data as good. It fills the shared store across two reads, which catches a third read that issues into space that is already spoken for. Drains with no completed data, foreign tags and out-of-range buffers must all leave the outputs unchanged.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_LIVE  = 2'd1,
    SL_STALE = 2'd2
  } slot_state_e;
endpackage

// File: rtl/drt_tag_codec.sv
module drt_tag_codec #(
  parameter int BUF_W = 2,
  parameter int SUB_W = 3,
  parameter int TAG_W = BUF_W + SUB_W
) (
  input  logic             wide,
  input  logic [BUF_W-1:0] enc_buf,
  input  logic [SUB_W-1:0] enc_sub,
  output logic [TAG_W-1:0] enc_tag,
  input  logic [TAG_W-1:0] dec_tag,
  output logic [BUF_W-1:0] dec_buf,
  output logic             dec_lead_ok
);
  // wide layout: more buffer bits, fewer subrequest bits
  always_comb begin
    if (wide) begin
      enc_tag = {1'b0, enc_buf, enc_sub[SUB_W-2:0]};
      dec_buf = dec_tag[TAG_W-2 -: BUF_W];
    end else begin
      enc_tag = {1'b0, enc_buf[BUF_W-2:0], enc_sub};
      dec_buf = {1'b0, dec_tag[TAG_W-2 -: BUF_W-1]};
    end
    dec_lead_ok = ~dec_tag[TAG_W-1];
  end
endmodule

// File: rtl/drt_pick.sv
module drt_pick #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/drt_slot.sv
module drt_slot
  import drt_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int LINE_W = 3,
  parameter int SUB_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cont,
  input  logic [LINE_W-1:0] cfg_lines_m1,
  input  logic [CNT_W-1:0]  out_cap,
  input  logic [SUB_W-1:0]  sub_mask,
  input  logic              start,
  input  logic              disc,
  input  logic              cpl,
  input  logic              drain,
  input  logic              grant,
  output logic              want,
  output logic [SUB_W-1:0]  sub_no,
  output logic              busy,
  output logic              stale,
  output logic              has_out,
  output logic              full,
  output logic [CNT_W-1:0]  held
);
  slot_state_e      state;
  logic [CNT_W-1:0] out_cnt;
  logic [CNT_W-1:0] issued;
  logic [CNT_W-1:0] lines;
  logic [CNT_W-1:0] out_nx;
  logic             cpl_ok;
  logic             drain_ok;

  assign lines    = CNT_W'(cfg_lines_m1) + CNT_W'(1);
  assign cpl_ok   = cpl && (out_cnt != '0);
  assign drain_ok = drain && (state == SL_LIVE) && (held > out_cnt);
  assign out_nx   = out_cnt - CNT_W'(cpl_ok) + CNT_W'(grant);

  assign busy    = (state != SL_IDLE);
  assign stale   = (state == SL_STALE);
  assign has_out = (out_cnt != '0);
  assign full    = busy && (out_cnt == out_cap);
  assign want    = (state == SL_LIVE) && (out_cnt < out_cap) &&
                   (cfg_cont ? (held < lines) : (issued < lines));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SL_IDLE;
      out_cnt <= '0;
      held    <= '0;
      issued  <= '0;
      sub_no  <= '0;
    end else begin
      case (state)
        SL_IDLE: begin
          if (start) begin
            state   <= SL_LIVE;
            out_cnt <= '0;
            held    <= '0;
            issued  <= '0;
            sub_no  <= '0;
          end
        end
        SL_LIVE: begin
          if (disc) begin
            // drained-side data is gone; only in-flight lines stay reserved
            out_cnt <= out_nx;
            held    <= out_nx;
            state   <= (out_nx == '0) ? SL_IDLE : SL_STALE;
          end else begin
            out_cnt <= out_nx;
            held    <= held + CNT_W'(grant) - CNT_W'(drain_ok);
            if (grant) begin
              if (issued != '1) issued <= issued + CNT_W'(1);
              sub_no <= (sub_no + SUB_W'(1)) & sub_mask;
            end
          end
        end
        SL_STALE: begin
          if (cpl_ok) begin
            out_cnt <= out_cnt - CNT_W'(1);
            held    <= held - CNT_W'(1);
            if (out_cnt == CNT_W'(1)) state <= SL_IDLE;
          end
        end
        default: state <= SL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/delayed_read_tracker.sv
module delayed_read_tracker #(
  parameter int NBUF       = 4,
  parameter int LINE_W     = 3,
  parameter int SUB_W      = 3,
  parameter int POOL_LINES = 16,
  localparam int BUF_W  = $clog2(NBUF),
  localparam int TAG_W  = BUF_W + SUB_W,
  localparam int CNT_W  = ((LINE_W > SUB_W) ? LINE_W : SUB_W) + 1,
  localparam int POOL_W = $clog2(NBUF * (1 << CNT_W) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUF_W-1:0]  cfg_nbuf,
  input  logic [LINE_W-1:0] cfg_lines_m1,
  input  logic              cfg_cont,
  input  logic              req_valid,
  input  logic [BUF_W-1:0]  req_buf,
  input  logic              drain_valid,
  input  logic [BUF_W-1:0]  drain_buf,
  input  logic              disc_valid,
  input  logic [BUF_W-1:0]  disc_buf,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  output logic              iss_valid,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              cpl_accept,
  output logic              cpl_drop,
  output logic [NBUF-1:0]   buf_busy,
  output logic [NBUF-1:0]   buf_full
);
  logic             wide;
  logic [CNT_W-1:0] out_cap;
  logic [SUB_W-1:0] sub_mask;
  logic [NBUF-1:0]  act_mask;

  logic [NBUF-1:0]  s_want, s_stale, s_hasout, s_start, s_disc, s_cpl, s_drain;
  logic [NBUF-1:0]  s_elig, s_gnt;
  logic [SUB_W-1:0] s_sub  [NBUF];
  logic [CNT_W-1:0] s_held [NBUF];

  logic [POOL_W-1:0] pool_used;
  logic              pool_ok;
  logic [BUF_W-1:0]  gnt_idx;
  logic              gnt_any;
  logic [TAG_W-1:0]  gnt_tag;
  logic [BUF_W-1:0]  cpl_bi;
  logic              cpl_lead_ok;
  logic              cpl_hit;
  logic              accept_d, drop_d;

  assign wide     = cfg_nbuf[BUF_W-1];
  assign out_cap  = wide ? CNT_W'(1 << (SUB_W - 1)) : CNT_W'(1 << SUB_W);
  assign sub_mask = wide ? SUB_W'((1 << (SUB_W - 1)) - 1) : '1;

  drt_tag_codec #(.BUF_W(BUF_W), .SUB_W(SUB_W), .TAG_W(TAG_W)) u_codec (
    .wide        (wide),
    .enc_buf     (gnt_idx),
    .enc_sub     (s_sub[gnt_idx]),
    .enc_tag     (gnt_tag),
    .dec_tag     (cpl_tag),
    .dec_buf     (cpl_bi),
    .dec_lead_ok (cpl_lead_ok)
  );

  assign cpl_hit = cpl_valid && cpl_lead_ok && act_mask[cpl_bi];

  always_comb begin
    pool_used = '0;
    for (int i = 0; i < NBUF; i++) pool_used += POOL_W'(s_held[i]);
  end
  assign pool_ok = (pool_used < POOL_W'(POOL_LINES));

  genvar g;
  generate
    for (g = 0; g < NBUF; g++) begin : g_slot
      assign act_mask[g] = (BUF_W'(g) <= cfg_nbuf);
      assign s_start[g]  = req_valid   && (req_buf   == BUF_W'(g)) && act_mask[g];
      assign s_disc[g]   = disc_valid  && (disc_buf  == BUF_W'(g)) && act_mask[g];
      assign s_drain[g]  = drain_valid && (drain_buf == BUF_W'(g)) && act_mask[g];
      assign s_cpl[g]    = cpl_hit && (cpl_bi == BUF_W'(g));
      assign s_elig[g]   = s_want[g] && !s_disc[g] && act_mask[g] && pool_ok;

      drt_slot #(.CNT_W(CNT_W), .LINE_W(LINE_W), .SUB_W(SUB_W)) u_slot (
        .clk          (clk),
        .rst          (rst),
        .cfg_cont     (cfg_cont),
        .cfg_lines_m1 (cfg_lines_m1),
        .out_cap      (out_cap),
        .sub_mask     (sub_mask),
        .start        (s_start[g]),
        .disc         (s_disc[g]),
        .cpl          (s_cpl[g]),
        .drain        (s_drain[g]),
        .grant        (s_gnt[g]),
        .want         (s_want[g]),
        .sub_no       (s_sub[g]),
        .busy         (buf_busy[g]),
        .stale        (s_stale[g]),
        .has_out      (s_hasout[g]),
        .full         (buf_full[g]),
        .held         (s_held[g])
      );
    end
  endgenerate

  drt_pick #(.N(NBUF), .IDX_W(BUF_W)) u_pick (
    .req (s_elig),
    .gnt (s_gnt),
    .idx (gnt_idx),
    .any (gnt_any)
  );

  assign accept_d = cpl_hit && buf_busy[cpl_bi] && !s_stale[cpl_bi] && s_hasout[cpl_bi];
  assign drop_d   = cpl_hit && s_stale[cpl_bi] && s_hasout[cpl_bi];

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= 1'b0;
      iss_tag    <= '0;
      cpl_accept <= 1'b0;
      cpl_drop   <= 1'b0;
    end else begin
      iss_valid  <= gnt_any;
      iss_tag    <= gnt_any ? gnt_tag : '0;
      cpl_accept <= accept_d;
      cpl_drop   <= drop_d;
    end
  end
endmodule

// File: rtl/drt_checker.sv
module drt_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_nbuf,
  input logic       cpl_valid,
  input logic       iss_valid,
  input logic [4:0] iss_tag,
  input logic       cpl_accept,
  input logic       cpl_drop,
  input logic [3:0] buf_busy,
  input logic [3:0] buf_full
);
  logic [1:0] ib;
  assign ib = cfg_nbuf[1] ? iss_tag[3:2] : {1'b0, iss_tag[3]};

  p_lead_zero_r2: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !iss_tag[4]);

  p_narrow_range_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !cfg_nbuf[1]) |-> (iss_tag[3] <= cfg_nbuf[0]));

  p_issuer_was_busy_r1: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (($past(buf_busy) & (4'b0001 << ib)) != 4'b0000));

  p_no_issue_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (($past(buf_full) & (4'b0001 << ib)) == 4'b0000));

  p_accept_drop_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(cpl_accept && cpl_drop));

  p_cpl_has_cause_r11: assert property (@(posedge clk) disable iff (rst)
    (cpl_accept || cpl_drop) |-> $past(cpl_valid));

  p_full_implies_busy_r5: assert property (@(posedge clk) disable iff (rst)
    ((buf_full & ~buf_busy) == 4'b0000));
endmodule

bind delayed_read_tracker drt_checker u_drt_checker (
  .clk        (clk),
  .rst        (rst),
  .cfg_nbuf   (cfg_nbuf),
  .cpl_valid  (cpl_valid),
  .iss_valid  (iss_valid),
  .iss_tag    (iss_tag),
  .cpl_accept (cpl_accept),
  .cpl_drop   (cpl_drop),
  .buf_busy   (buf_busy),
  .buf_full   (buf_full)
);

// File: tb/delayed_read_tracker_test.sv
module delayed_read_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_nbuf = 2'd3;
  logic [2:0] cfg_lines_m1 = 3'd0;
  logic       cfg_cont = 1'b0;
  logic       req_valid = 1'b0, drain_valid = 1'b0, disc_valid = 1'b0, cpl_valid = 1'b0;
  logic [1:0] req_buf = '0, drain_buf = '0, disc_buf = '0;
  logic [4:0] cpl_tag = '0;
  logic       iss_valid, cpl_accept, cpl_drop;
  logic [4:0] iss_tag;
  logic [3:0] buf_busy, buf_full;

  int tests = 0;
  int fails = 0;
  logic [4:0] tlog [64];
  int nlog = 0, nacc = 0, ndrop = 0;

  delayed_read_tracker uut (
    .clk(clk), .rst(rst), .cfg_nbuf(cfg_nbuf), .cfg_lines_m1(cfg_lines_m1),
    .cfg_cont(cfg_cont), .req_valid(req_valid), .req_buf(req_buf),
    .drain_valid(drain_valid), .drain_buf(drain_buf), .disc_valid(disc_valid),
    .disc_buf(disc_buf), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .cpl_accept(cpl_accept),
    .cpl_drop(cpl_drop), .buf_busy(buf_busy), .buf_full(buf_full)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (iss_valid) begin
        if (nlog < 64) tlog[nlog] = iss_tag;
        nlog++;
      end
      if (cpl_accept) nacc++;
      if (cpl_drop) ndrop++;
    end
  end

  function automatic logic [4:0] etag(int nb, int b, int k);
    if (nb >= 2) return {1'b0, 2'(b), 2'(k % 4)};
    return {1'b0, 1'(b), 3'(k % 8)};
  endfunction

  task automatic chk(string rq, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset(int nb, int lm1, bit cont);
    rst = 1'b1;
    cfg_nbuf = 2'(nb);
    cfg_lines_m1 = 3'(lm1);
    cfg_cont = cont;
    idle(2);
    rst = 1'b0;
    nlog = 0; nacc = 0; ndrop = 0;
    tick();
  endtask

  task automatic req(int b);
    req_valid = 1'b1; req_buf = 2'(b); tick(); req_valid = 1'b0;
  endtask

  task automatic drain(int b);
    drain_valid = 1'b1; drain_buf = 2'(b); tick(); drain_valid = 1'b0;
  endtask

  task automatic disc(int b);
    disc_valid = 1'b1; disc_buf = 2'(b); tick(); disc_valid = 1'b0;
  endtask

  task automatic cpl(logic [4:0] t);
    cpl_valid = 1'b1; cpl_tag = t; tick(); cpl_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R12: reset state
    do_reset(3, 0, 0);
    chk("R12 iss_valid", int'(iss_valid), 0);
    chk("R12 busy", int'(buf_busy), 0);
    chk("R12 full", int'(buf_full), 0);

    // R2 / R3 / R6 / R10: sweep buffer counts and buffers, two-line single reads
    for (int nb = 0; nb < 4; nb++) begin
      for (int b = 0; b <= nb; b++) begin
        do_reset(nb, 1, 0);
        req(b);
        idle(8);
        chk("R6 two lines issued", nlog, 2);
        chk(nb >= 2 ? "R2 tag sub0" : "R3 tag sub0", int'(tlog[0]), int'(etag(nb, b, 0)));
        chk(nb >= 2 ? "R2 tag sub1" : "R3 tag sub1", int'(tlog[1]), int'(etag(nb, b, 1)));
        cpl(tlog[0]);
        cpl(tlog[1]);
        idle(2);
        chk("R11 accepts", nacc, 2);
        chk("R10 busy before disc", int'(buf_busy[b]), 1);
        disc(b);
        idle(1);
        chk("R10 freed with nothing in flight", int'(buf_busy[b]), 0);
      end
      if (nb < 3) begin
        // R1: buffer beyond the active count is ignored
        do_reset(nb, 1, 0);
        req(nb + 1);
        idle(6);
        chk("R1 out-of-range issues", nlog, 0);
        chk("R1 out-of-range busy", int'(buf_busy), 0);
      end
    end

    // R5 / R4 / R6: in-flight cap and subrequest wrap, both layouts
    for (int v = 0; v < 2; v++) begin
      int nb = (v == 0) ? 3 : 0;
      int cap = (nb >= 2) ? 4 : 8;
      do_reset(nb, 7, 0);
      req(0);
      idle(12);
      chk("R5 cap reached", nlog, cap);
      chk("R5 full flag", int'(buf_full[0]), 1);
      for (int i = 0; i < cap; i++) cpl(tlog[i]);
      idle(12);
      chk("R6 eight lines total", nlog, 8);
      for (int k = 0; k < 8; k++)
        chk("R4 numbering and wrap", int'(tlog[k]), int'(etag(nb, 0, k)));
      for (int i = cap; i < 8; i++) cpl(tlog[i]);
      idle(6);
      chk("R6 stops after line count", nlog, 8);
      chk("R5 full clears", int'(buf_full[0]), 0);
    end

    // R7: continuous window of two lines
    do_reset(3, 1, 1);
    req(2);
    idle(6);
    chk("R7 window fills", nlog, 2);
    drain(2);
    idle(4);
    chk("R7 drain with no data ignored", nlog, 2);
    cpl(tlog[0]);
    idle(4);
    chk("R7 completion alone frees nothing", nlog, 2);
    drain(2);
    idle(4);
    chk("R7 drain refills window", nlog, 3);
    chk("R7 refill tag", int'(tlog[2]), int'(etag(3, 2, 2)));

    // R10 / R1 / R4: disconnect with subrequests in flight
    do_reset(3, 7, 0);
    req(1);
    idle(8);
    chk("R10 setup issues", nlog, 4);
    cpl(tlog[0]);
    disc(1);
    idle(2);
    chk("R10 stale stays busy", int'(buf_busy[1]), 1);
    req(1);
    idle(4);
    chk("R1 busy buffer request ignored", nlog, 4);
    cpl(tlog[1]);
    cpl(tlog[2]);
    idle(2);
    chk("R10 stale completions dropped", ndrop, 2);
    chk("R10 still busy", int'(buf_busy[1]), 1);
    cpl(tlog[3]);
    idle(2);
    chk("R10 freed after last", int'(buf_busy[1]), 0);
    chk("R10 drop count", ndrop, 3);
    chk("R11 accept count", nacc, 1);
    req(1);
    idle(6);
    chk("R4 restart issues", nlog, 8);
    chk("R4 restart at zero", int'(tlog[4]), int'(etag(3, 1, 0)));

    // R11: foreign and idle-buffer completions
    do_reset(3, 1, 0);
    req(0);
    idle(6);
    cpl(tlog[0] | 5'h10);
    cpl({1'b0, 2'd3, 2'd0});
    idle(2);
    chk("R11 ignored accept", nacc, 0);
    chk("R11 ignored drop", ndrop, 0);
    cpl(tlog[0]);
    idle(2);
    chk("R11 good completion", nacc, 1);

    // R9: lowest buffer wins
    do_reset(3, 1, 0);
    req(1);
    req(0);
    idle(8);
    chk("R9 count", nlog, 4);
    chk("R9 order 0", int'(tlog[0]), int'(etag(3, 1, 0)));
    chk("R9 order 1", int'(tlog[1]), int'(etag(3, 0, 0)));
    chk("R9 order 2", int'(tlog[2]), int'(etag(3, 0, 1)));
    chk("R9 order 3", int'(tlog[3]), int'(etag(3, 1, 1)));

    // R8: shared store of 16 lines
    do_reset(3, 7, 0);
    req(0);
    idle(8);
    for (int i = 0; i < 4; i++) cpl(tlog[i]);
    idle(8);
    for (int i = 4; i < 8; i++) cpl(tlog[i]);
    req(1);
    idle(8);
    for (int i = 8; i < 12; i++) cpl(tlog[i]);
    idle(8);
    for (int i = 12; i < 16; i++) cpl(tlog[i]);
    chk("R8 two reads filled", nlog, 16);
    req(2);
    idle(8);
    chk("R8 third read waits", nlog, 16);
    chk("R8 third read busy", int'(buf_busy[2]), 1);
    drain(0);
    idle(6);
    chk("R8 drain makes room", nlog, 17);
    chk("R8 room tag", int'(tlog[16]), int'(etag(3, 2, 0)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule